// File: doc/BRIEF.md
# Transmit Queue Pending Descriptor Counter

This block keeps two counts for one transmit queue. The first is the number of descriptors that software has prepared and that the DMA engine has not yet sent. The second is the number of descriptors that have been sent and that software has not yet released. Software uses one update word for both jobs: the low field posts new descriptors and the upper field releases sent ones. Software polls a status word and treats a pending count of zero as the end of transmission.

Toward the DMA engine, the block raises `desc_avail_o` while its queue is enabled and work is pending. The DMA engine answers with a one-cycle `sent_i` pulse for each descriptor it finishes. A queue-command word enables or disables queues through one bit per queue, and only the queue chosen by `QIDX` is acted on. A separate level input holds the counts at zero. The error flag is sticky and records any clamped release and any saturated count.

A small state machine drives the handshake and has four states:
- `ST_OFF`: the queue is disabled.
- `ST_IDLE`: the queue is enabled and nothing is pending.
- `ST_BUSY`: the queue is enabled and work is pending. This is the only state that asserts `desc_avail_o`.
- `ST_HOLD`: the queue reset input is high.

Its transitions are:
- reset → `ST_OFF`.
- Any state → `ST_HOLD` while `qrst_i` is high.
- `ST_HOLD` → `ST_OFF`, `ST_IDLE` or `ST_BUSY` once `qrst_i` falls, chosen by the enable and the pending count.
- `ST_OFF` → `ST_IDLE` or `ST_BUSY` on enable.
- `ST_IDLE` ↔ `ST_BUSY` as the pending count leaves or reaches zero.
- `ST_IDLE` or `ST_BUSY` → `ST_OFF` on disable.

Every output is registered. Each input takes effect on the outputs one clock after the edge that samples it.

Top module: `txq_pend_ctr`

## Requirements
- R1: After `rst_n` is released, `status_o` reads 0, `desc_avail_o` is 0 and the queue is disabled.
- R2: An update with `upd_word_i[15:0]` = N adds N to the pending count. The pending count is reported in `status_o[13:0]`.
- R3: An update with `upd_word_i[31:16]` = M subtracts M from the sent count. The sent count is reported in `status_o[29:16]`. A single update word may post and release in the same write.
- R4: A `sent_i` pulse taken while `desc_avail_o` is 1 lowers the pending count by one and raises the sent count by one. An update in the same cycle combines with the pulse.
- R5: A `sent_i` pulse while `desc_avail_o` is 0 leaves both counts unchanged.
- R6: `desc_avail_o` is 1 exactly when the queue is enabled and the pending count is non-zero.
- R7: In the queue-command word, bit `QIDX` enables the queue and bit `8+QIDX` disables it. If both bits are set, disable wins. Bits for other queues have no effect on this queue. Enabling or disabling keeps both counts.
- R8: A release larger than the sent count (after that cycle's pulse) sets the sent count to 0 and sets the error flag `status_o[31]`.
- R9: A post that would take the pending count above 16383 saturates it at 16383 and sets the error flag.
- R10: While `qrst_i` is 1, both counts and the error flag read 0 and updates and pulses are ignored. Queue commands still act, and the enable is kept.
- R11: Once set, the error flag stays set until `qrst_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid_i | input | 1 | Update word write strobe |
| upd_word_i | input | 32 | Update word: [15:0] post count, [31:16] release count |
| qcmd_valid_i | input | 1 | Queue-command write strobe |
| qcmd_word_i | input | 16 | Queue command: [7:0] enable, [15:8] disable, one bit per queue |
| qrst_i | input | 1 | Queue reset level; holds counts and error at zero |
| sent_i | input | 1 | One-cycle pulse from the DMA engine per descriptor sent |
| desc_avail_o | output | 1 | Work pending toward the DMA engine |
| status_o | output | 32 | [13:0] pending, [29:16] sent, [31] error |

## Verification
The hardest case to reach is one where a release, a post and a sent pulse all land in the same cycle on the boundary of the sent count. In that cycle, whether the release clamps depends on the pulse that arrives with it. Directed steps build up a known sent count and then issue a release exactly one larger than the stored count, together with a pulse, so the pulse keeps the release legal. They then repeat the release without the pulse so that it clamps. A long random phase then mixes all inputs against a behavioural model on every clock.

// File: rtl/txq_pend_pkg.sv
package txq_pend_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2,
        ST_HOLD = 2'd3
    } txq_state_e;
endpackage

// File: rtl/txq_cmd_decode.sv
module txq_cmd_decode #(
    parameter int NUM_Q = 8,
    parameter int QIDX  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid_i,
    input  logic [2*NUM_Q-1:0] cmd_word_i,
    output logic               en_q_o,
    output logic               en_nxt_o
);
    localparam int EN_BIT  = QIDX;
    localparam int DIS_BIT = NUM_Q + QIDX;

    logic en_q;

    // Disable takes priority over enable within one command write.
    always_comb begin
        en_nxt_o = en_q;
        if (cmd_valid_i) begin
            if (cmd_word_i[DIS_BIT])
                en_nxt_o = 1'b0;
            else if (cmd_word_i[EN_BIT])
                en_nxt_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= en_nxt_o;
    end

    assign en_q_o = en_q;
endmodule

// File: rtl/txq_count_core.sv
module txq_count_core #(
    parameter int CNT_W = 14,
    parameter int FLD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [FLD_W-1:0] add_i,
    input  logic [FLD_W-1:0] rls_i,
    input  logic             take_i,
    output logic [CNT_W-1:0] pend_o,
    output logic [CNT_W-1:0] sent_o,
    output logic             err_o,
    output logic             pend_nz_nxt_o
);
    localparam int SUM_W = FLD_W + 2;
    localparam logic [SUM_W-1:0] MAXV = SUM_W'((2 ** CNT_W) - 1);

    logic [CNT_W-1:0] pend_q, sent_q, pend_d, sent_d;
    logic             err_q, err_d;
    logic [SUM_W-1:0] p_sum, s_sum;

    always_comb begin
        // take_i only arrives while the pending count is non-zero
        p_sum  = SUM_W'(pend_q) + SUM_W'(add_i) - SUM_W'(take_i);
        s_sum  = SUM_W'(sent_q) + SUM_W'(take_i);
        err_d  = err_q;
        if (p_sum > MAXV) begin
            p_sum = MAXV;
            err_d = 1'b1;
        end
        if (s_sum > MAXV) begin
            s_sum = MAXV;
            err_d = 1'b1;
        end
        if (SUM_W'(rls_i) > s_sum) begin
            s_sum = '0;
            err_d = 1'b1;
        end else begin
            s_sum = s_sum - SUM_W'(rls_i);
        end
        pend_d = p_sum[CNT_W-1:0];
        sent_d = s_sum[CNT_W-1:0];
        if (hold_i) begin
            pend_d = '0;
            sent_d = '0;
            err_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sent_q <= '0;
            err_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            sent_q <= sent_d;
            err_q  <= err_d;
        end
    end

    assign pend_o        = pend_q;
    assign sent_o        = sent_q;
    assign err_o         = err_q;
    assign pend_nz_nxt_o = |pend_d;
endmodule

// File: rtl/txq_state_fsm.sv
module txq_state_fsm
    import txq_pend_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_i,
    input  logic       en_nxt_i,
    input  logic       pend_nz_nxt_i,
    output txq_state_e state_o,
    output logic       avail_o
);
    txq_state_e state_q, state_d;

    always_comb begin
        if (hold_i)
            state_d = ST_HOLD;
        else if (!en_nxt_i)
            state_d = ST_OFF;
        else if (pend_nz_nxt_i)
            state_d = ST_BUSY;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OFF:  avail_o = 1'b0;
            ST_IDLE: avail_o = 1'b0;
            ST_BUSY: avail_o = 1'b1;
            ST_HOLD: avail_o = 1'b0;
            default: avail_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/txq_pend_ctr.sv
module txq_pend_ctr
    import txq_pend_pkg::*;
#(
    parameter int NUM_Q = 8,
    parameter int QIDX  = 0,
    parameter int CNT_W = 14,
    parameter int FLD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid_i,
    input  logic [2*FLD_W-1:0] upd_word_i,
    input  logic               qcmd_valid_i,
    input  logic [2*NUM_Q-1:0] qcmd_word_i,
    input  logic               qrst_i,
    input  logic               sent_i,
    output logic               desc_avail_o,
    output logic [2*FLD_W-1:0] status_o
);
    localparam int UPD_W = 2 * FLD_W;

    logic             en_q, en_nxt, pend_nz_nxt, err, take;
    logic [CNT_W-1:0] pend, sent;
    logic [FLD_W-1:0] add_cnt, rls_cnt;
    txq_state_e       state;

    assign add_cnt = upd_valid_i ? upd_word_i[FLD_W-1:0]     : '0;
    assign rls_cnt = upd_valid_i ? upd_word_i[UPD_W-1:FLD_W] : '0;
    assign take    = sent_i & desc_avail_o & ~qrst_i;

    txq_cmd_decode #(.NUM_Q(NUM_Q), .QIDX(QIDX)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(qcmd_valid_i),
        .cmd_word_i (qcmd_word_i),
        .en_q_o     (en_q),
        .en_nxt_o   (en_nxt)
    );

    txq_count_core #(.CNT_W(CNT_W), .FLD_W(FLD_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_i       (qrst_i),
        .add_i        (add_cnt),
        .rls_i        (rls_cnt),
        .take_i       (take),
        .pend_o       (pend),
        .sent_o       (sent),
        .err_o        (err),
        .pend_nz_nxt_o(pend_nz_nxt)
    );

    txq_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_i       (qrst_i),
        .en_nxt_i     (en_nxt),
        .pend_nz_nxt_i(pend_nz_nxt),
        .state_o      (state),
        .avail_o      (desc_avail_o)
    );

    always_comb begin
        status_o                      = '0;
        status_o[CNT_W-1:0]           = pend;
        status_o[FLD_W+CNT_W-1:FLD_W] = sent;
        status_o[UPD_W-1]             = err;
    end

    logic unused_ok;
    assign unused_ok = en_q ^ state[0];
endmodule

// File: rtl/txq_pend_chk.sv
module txq_pend_chk #(
    parameter int NUM_Q = 8,
    parameter int QIDX  = 0,
    parameter int CNT_W = 14,
    parameter int FLD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               upd_valid_i,
    input logic               qcmd_valid_i,
    input logic [2*NUM_Q-1:0] qcmd_word_i,
    input logic               qrst_i,
    input logic               sent_i,
    input logic               desc_avail_o,
    input logic [2*FLD_W-1:0] status_o
);
    logic [CNT_W-1:0] pend;
    logic             err;

    assign pend = status_o[CNT_W-1:0];
    assign err  = status_o[2*FLD_W-1];

    assert_avail_needs_work_R6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_avail_o |-> (pend != '0));

    assert_pulse_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_avail_o && sent_i && !upd_valid_i && !qrst_i) |=>
        (pend == $past(pend) - 1'b1));

    assert_idle_pulse_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_avail_o && sent_i && !upd_valid_i && !qrst_i) |=> $stable(pend));

    assert_disable_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (qcmd_valid_i && qcmd_word_i[NUM_Q+QIDX]) |=> !desc_avail_o);

    assert_hold_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        qrst_i |=> (status_o == '0) && !desc_avail_o);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !qrst_i) |=> err);
endmodule

bind txq_pend_ctr txq_pend_chk #(
    .NUM_Q(NUM_Q), .QIDX(QIDX), .CNT_W(CNT_W), .FLD_W(FLD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_valid_i (upd_valid_i),
    .qcmd_valid_i(qcmd_valid_i),
    .qcmd_word_i (qcmd_word_i),
    .qrst_i      (qrst_i),
    .sent_i      (sent_i),
    .desc_avail_o(desc_avail_o),
    .status_o    (status_o)
);

// File: tb/txq_pend_ctr_tb.sv
module txq_pend_ctr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = 16383;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_word_i = '0;
    logic        qcmd_valid_i = 1'b0;
    logic [15:0] qcmd_word_i = '0;
    logic        qrst_i = 1'b0;
    logic        sent_i = 1'b0;
    logic        desc_avail_o;
    logic [31:0] status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    bit m_en  = 0;
    int m_pend = 0;
    int m_sent = 0;
    bit m_err  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txq_pend_ctr dut_i (
        .clk(clk), .rst_n(rst_n), .upd_valid_i(upd_valid_i), .upd_word_i(upd_word_i),
        .qcmd_valid_i(qcmd_valid_i), .qcmd_word_i(qcmd_word_i), .qrst_i(qrst_i),
        .sent_i(sent_i), .desc_avail_o(desc_avail_o), .status_o(status_o)
    );

    function automatic logic [31:0] exp_status();
        logic [31:0] v = '0;
        v[13:0]  = m_pend[13:0];
        v[29:16] = m_sent[13:0];
        v[31]    = m_err;
        return v;
    endfunction

    task automatic model_edge();
        bit take = sent_i && m_en && (m_pend != 0) && !qrst_i;
        int add  = upd_valid_i ? int'(upd_word_i[15:0])  : 0;
        int rls  = upd_valid_i ? int'(upd_word_i[31:16]) : 0;
        if (qcmd_valid_i) begin
            if (qcmd_word_i[8]) m_en = 0;
            else if (qcmd_word_i[0]) m_en = 1;
        end
        if (qrst_i) begin
            m_pend = 0; m_sent = 0; m_err = 0;
        end else begin
            m_pend = m_pend + add - (take ? 1 : 0);
            if (m_pend > MAXV) begin m_pend = MAXV; m_err = 1; end
            m_sent = m_sent + (take ? 1 : 0);
            if (m_sent > MAXV) begin m_sent = MAXV; m_err = 1; end
            if (rls > m_sent) begin m_sent = 0; m_err = 1; end
            else m_sent = m_sent - rls;
        end
    endtask

    task automatic compare(input string tag);
        logic exp_av = m_en && (m_pend != 0);
        checks++;
        if (status_o !== exp_status()) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h", tag, status_o, exp_status());
        end
        checks++;
        if (desc_avail_o !== exp_av) begin
            fails++;
            $display("FAIL %s avail actual=%b expected=%b", tag, desc_avail_o, exp_av);
        end
    endtask

    // inputs are applied at the falling edge, results compared at the next one
    task automatic step(input bit uv, input logic [31:0] uw, input bit cv,
                        input logic [15:0] cw, input bit qr, input bit s, input string tag);
        upd_valid_i = uv; upd_word_i = uw; qcmd_valid_i = cv; qcmd_word_i = cw;
        qrst_i = qr; sent_i = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        upd_valid_i = 0; qcmd_valid_i = 0; qrst_i = 0; sent_i = 0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, '0, 0, '0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        // R1: queue disabled after reset, post gives no avail
        step(1, 32'h0000_0003, 0, '0, 0, 0, "R1");
        // R7 enable; R6 avail rises
        step(0, '0, 1, 16'h0001, 0, 0, "R7");
        // R2 additional post
        step(1, 32'h0000_0002, 0, '0, 0, 0, "R2");
        // R4 pulses drain
        step(0, '0, 0, '0, 0, 1, "R4");
        step(0, '0, 0, '0, 0, 1, "R4");
        // R3 + R4 combined: post 1, release 1, pulse
        step(1, 32'h0001_0001, 0, '0, 0, 1, "R3");
        // R7 disable keeps counts; R5 pulse ignored while disabled
        step(0, '0, 1, 16'h0100, 0, 0, "R7");
        step(0, '0, 0, '0, 0, 1, "R5");
        // R7 both bits: disable wins; other-queue bits ignored
        step(0, '0, 1, 16'h0101, 0, 0, "R7");
        step(0, '0, 1, 16'h00FE, 0, 0, "R7");
        step(0, '0, 1, 16'h0200, 0, 0, "R7");
        step(0, '0, 1, 16'h0001, 0, 0, "R6");
        // drain to zero then pulse with nothing pending (R5)
        for (int i = 0; i < 4; i++) step(0, '0, 0, '0, 0, 1, "R4");
        step(0, '0, 0, '0, 0, 1, "R5");
        // boundary: release one more than stored, made legal by a same-cycle pulse
        step(1, 32'h0000_0001, 0, '0, 0, 0, "R2");
        step(1, 32'h0000_0000 | (32'(m_sent + 1) << 16), 0, '0, 0, 1, "R3");
        // R8 over-release clamps
        step(1, 32'h0001_0000, 0, '0, 0, 0, "R8");
        // R11 sticky through normal traffic
        step(1, 32'h0000_0002, 0, '0, 0, 0, "R11");
        step(0, '0, 0, '0, 0, 1, "R11");
        // R10 hold: cleared, updates ignored, enable kept
        step(1, 32'h0000_0005, 0, '0, 1, 1, "R10");
        step(1, 32'h0000_0005, 0, '0, 1, 0, "R10");
        step(1, 32'h0000_0001, 0, '0, 0, 0, "R10");
        // R9 saturation
        step(1, 32'h0000_FFFF, 0, '0, 0, 0, "R9");
        step(1, 32'h0000_0001, 0, '0, 0, 1, "R9");
        step(0, '0, 0, '0, 1, 0, "R10");
        // random mix against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            bit uv = (r < 30);
            logic [31:0] uw = {16'($urandom_range(0, 2)), 16'($urandom_range(0, 3))};
            bit cv = (r >= 90);
            logic [15:0] cw = 16'($urandom);
            bit qr = (r == 50);
            bit s  = ($urandom_range(0, 1) == 1);
            step(uv, uw, cv, cw, qr, s, "R4");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule